// File: doc/BRIEF.md
# Masked Vector Mantissa Extractor with Lane Merge

This block applies a per-element double-precision mantissa extraction to a vector of up to eight 64-bit lanes held in a 512-bit register image. Each computed lane is rescaled into one of four intervals, and its sign is chosen by a shared 4-bit control field. The active vector width is picked on every request: 128, 256 or 512 bits, which gives 2, 4 or 8 lanes. An 8-bit lane mask, when enabled, picks which lanes are computed. Each lane that is not computed either keeps its old destination value (merge) or is cleared (zeroing). A broadcast bit feeds lane 0 of the source to every lane.

A request is taken when `in_valid` is high. The whole 512-bit result, the two exception summaries and an encoding-fault flag are registered and appear one clock later with `out_valid`. The registered outputs hold their values until the next accepted request. An encoding-check nibble must read 4'b1111. Any other value flags an undefined operation, and the destination comes back as the old destination, unchanged.

Top module: `vec_mant_merge`

## Requirements
- R1: `vlen_sel` 2'b00 selects 2 active lanes, 2'b01 selects 4, and 2'b10 or 2'b11 selects 8. Lane i occupies bits [64i+63:64i]. Every destination bit at or above 64 x (active lanes) is zero.
- R2: With `mask_en` low, every active lane is computed, whatever `lane_mask` holds.
- R3: With `mask_en` high, an active lane whose `lane_mask` bit is 0 keeps its `old_dst` value when `zero_mode` is 0.
- R4: With `mask_en` high, an active lane whose `lane_mask` bit is 0 becomes zero when `zero_mode` is 1.
- R5: With `bcast` high, every computed lane takes source bits [63:0] as its input.
- R6: For a finite nonzero input, the result keeps the input fraction (normalized first if the input is subnormal). Its biased exponent is picked by `ctrl[1:0]`:
  - 00 gives 1023.
  - 01 gives 1022 when the unbiased input exponent is odd, and 1023 otherwise.
  - 10 gives 1022.
  - 11 gives 1022 when the top fraction bit is 1, and 1023 otherwise.
- R7: The result sign is 0 when `ctrl[2]` is 1 and the input sign otherwise. The special inputs give these results:
  - A NaN becomes quiet, with fraction bit 51 set.
  - +0 and +inf give +1.0 (64'h3FF0000000000000).
  - -0 gives +1.0 when `ctrl[2]` is 1 and -1.0 otherwise.
  - -inf gives the same as -0 when `ctrl[3]` is 0.
  - With `ctrl[3]` set, any negative input other than -0 and NaN gives 64'hFFF8000000000000.
- R8: `flag_inv` is the OR over computed lanes of these conditions: the input is a signalling NaN (fraction bit 51 clear), or the input is negative and the result is 64'hFFF8000000000000. `flag_den` is the OR over computed lanes of subnormal inputs that were normalized. Lanes that are masked off or outside the vector length do not contribute.
- R9: If `enc_chk` is not 4'b1111, then `undef_op` is 1, `dst` equals `old_dst` in full, and both flags are 0.
- R10: Reset clears `out_valid`, `dst`, the flags and `undef_op`. The outputs of an accepted request appear on the next clock, with `out_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| vlen_sel | input | 2 | Vector length select |
| src | input | 512 | Source vector |
| old_dst | input | 512 | Previous destination value |
| lane_mask | input | 8 | Per-lane compute mask |
| mask_en | input | 1 | Mask in use |
| zero_mode | input | 1 | Masked-off lanes are cleared instead of merged |
| bcast | input | 1 | Use source lane 0 for all lanes |
| ctrl | input | 4 | [3:2] sign control, [1:0] interval |
| enc_chk | input | 4 | Encoding check, must be 4'b1111 |
| out_valid | output | 1 | Result valid |
| dst | output | 512 | Result vector |
| flag_inv | output | 1 | Invalid-operation summary |
| flag_den | output | 1 | Subnormal-input summary |
| undef_op | output | 1 | Encoding fault |

## Verification
On every request, the assertions check these rules:
- The strobe is followed by a valid output.
- A bad encoding returns the old destination and clears the flags.
- The 128-bit width leaves the upper 384 bits zero.
- An all-zero mask either clears the vector or returns the old destination, as `zero_mode` selects.

Only the bench's scenarios can show the per-lane arithmetic, which covers the interval exponent choice, subnormal normalization, NaN quieting and the sign-control special cases. The same holds for broadcast replication and for flags gathered only from computed lanes under mixed masks. The bench compares every lane, flag and strobe against a behavioural model on each clock.

// File: rtl/vec_mant_merge.sv
module vec_mant_merge #(
  parameter int LANES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [1:0]         vlen_sel,
  input  logic [LANES*64-1:0] src,
  input  logic [LANES*64-1:0] old_dst,
  input  logic [LANES-1:0]   lane_mask,
  input  logic               mask_en,
  input  logic               zero_mode,
  input  logic               bcast,
  input  logic [3:0]         ctrl,
  input  logic [3:0]         enc_chk,
  output logic               out_valid,
  output logic [LANES*64-1:0] dst,
  output logic               flag_inv,
  output logic               flag_den,
  output logic               undef_op
);
  localparam int W = LANES * 64;
  localparam logic [63:0] ONE   = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] INDEF = 64'hFFF8_0000_0000_0000;

  // returns {invalid, denormal, result}
  function automatic logic [65:0] lane_op(input logic [63:0] x, input logic [3:0] c);
    logic        s;
    logic [10:0] e;
    logic [51:0] f;
    logic [51:0] mf;
    logic [63:0] sone;
    logic [10:0] ne;
    logic        odd;
    logic        den;
    int          p;
    int          sh;
    s = x[63];
    e = x[62:52];
    f = x[51:0];
    sone = c[2] ? ONE : {1'b1, ONE[62:0]};
    if (e == 11'h7FF && f != '0)
      return {~f[51], 1'b0, s, 11'h7FF, 1'b1, f[50:0]};
    if (e == 11'h7FF || (e == '0 && f == '0)) begin
      if (!s) return {2'b00, ONE};
      if (e == '0) return {2'b00, sone};
      return c[3] ? {2'b10, INDEF} : {2'b00, sone};
    end
    if (s && c[3]) return {2'b10, INDEF};
    den = (e == '0);
    p = 0;
    for (int i = 0; i < 52; i++) if (f[i]) p = i;
    sh = 52 - p;
    if (den) begin
      mf  = f << sh;
      odd = sh[0];
    end else begin
      mf  = f;
      odd = ~e[0];
    end
    case (c[1:0])
      2'b00:   ne = 11'd1023;
      2'b01:   ne = odd ? 11'd1022 : 11'd1023;
      2'b10:   ne = 11'd1022;
      default: ne = mf[51] ? 11'd1022 : 11'd1023;
    endcase
    return {1'b0, den, (c[2] ? 1'b0 : s), ne, mf};
  endfunction

  logic [3:0]       n_act;
  logic [W-1:0]     nxt;
  logic [LANES-1:0] inv_v, den_v;
  wire              enc_ok = (enc_chk == 4'b1111);

  always_comb begin
    case (vlen_sel)
      2'b00:   n_act = 4'd2;
      2'b01:   n_act = 4'd4;
      default: n_act = 4'd8;
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    wire [63:0] a    = bcast ? src[63:0] : src[g*64 +: 64];
    wire [65:0] r    = lane_op(a, ctrl);
    wire        on   = (g < int'(n_act));
    wire        take = on && (!mask_en || lane_mask[g]);
    assign nxt[g*64 +: 64] = !on ? 64'd0 :
                             take ? r[63:0] :
                             zero_mode ? 64'd0 : old_dst[g*64 +: 64];
    assign inv_v[g] = take & r[65];
    assign den_v[g] = take & r[64];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dst       <= '0;
      flag_inv  <= 1'b0;
      flag_den  <= 1'b0;
      undef_op  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        undef_op <= !enc_ok;
        dst      <= enc_ok ? nxt : old_dst;
        flag_inv <= enc_ok && (|inv_v);
        flag_den <= enc_ok && (|den_v);
      end
    end
  end
endmodule

module vec_mant_merge_chk #(
  parameter int LANES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [1:0]         vlen_sel,
  input logic [LANES*64-1:0] old_dst,
  input logic [LANES-1:0]   lane_mask,
  input logic               mask_en,
  input logic               zero_mode,
  input logic [3:0]         enc_chk,
  input logic               out_valid,
  input logic [LANES*64-1:0] dst,
  input logic               flag_inv,
  input logic               flag_den,
  input logic               undef_op
);
  localparam int W = LANES * 64;

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R9
  bad_enc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && enc_chk != 4'b1111) |=>
      (undef_op && dst == $past(old_dst) && !flag_inv && !flag_den));

  // R1
  upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && enc_chk == 4'b1111 && vlen_sel == 2'b00) |=> (dst[W-1:128] == '0));

  // R4
  zero_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && enc_chk == 4'b1111 && mask_en && zero_mode && lane_mask == '0) |=>
      (dst == '0 && !flag_inv && !flag_den && !undef_op));

  // R3
  merge_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && enc_chk == 4'b1111 && mask_en && !zero_mode && lane_mask == '0 && vlen_sel[1]) |=>
      (dst == $past(old_dst) && !flag_inv && !flag_den));
endmodule

bind vec_mant_merge vec_mant_merge_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .vlen_sel(vlen_sel),
  .old_dst(old_dst), .lane_mask(lane_mask), .mask_en(mask_en),
  .zero_mode(zero_mode), .enc_chk(enc_chk), .out_valid(out_valid),
  .dst(dst), .flag_inv(flag_inv), .flag_den(flag_den), .undef_op(undef_op)
);

// File: tb/sim_vec_mant_merge.sv
`timescale 1ns/1ps
module sim_vec_mant_merge;
  localparam int L = 8;
  localparam int W = L * 64;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [1:0]    vlen_sel = '0;
  logic [W-1:0]  src = '0, old_dst = '0;
  logic [L-1:0]  lane_mask = '0;
  logic          mask_en = 1'b0, zero_mode = 1'b0, bcast = 1'b0;
  logic [3:0]    ctrl = '0;
  logic [3:0]    enc_chk = 4'b1111;
  logic          out_valid, flag_inv, flag_den, undef_op;
  logic [W-1:0]  dst;

  vec_mant_merge #(.LANES(L)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .vlen_sel(vlen_sel),
    .src(src), .old_dst(old_dst), .lane_mask(lane_mask), .mask_en(mask_en),
    .zero_mode(zero_mode), .bcast(bcast), .ctrl(ctrl), .enc_chk(enc_chk),
    .out_valid(out_valid), .dst(dst), .flag_inv(flag_inv),
    .flag_den(flag_den), .undef_op(undef_op)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  logic [W-1:0] m_dst = '0;
  logic m_valid = 0, m_inv = 0, m_den = 0, m_undef = 0;
  string m_tag [L];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_mant(input logic [63:0] x, input logic [3:0] c,
                                           output bit iv, output bit dn);
    logic sg; int ex; logic [51:0] fr; int ue; bit odd; bit j;
    logic [63:0] one, sone;
    iv = 0; dn = 0;
    sg = x[63]; ex = int'(x[62:52]); fr = x[51:0];
    one  = 64'h3FF0_0000_0000_0000;
    sone = c[2] ? one : (one | 64'h8000_0000_0000_0000);
    if (ex == 2047) begin
      if (fr != 0) begin iv = !fr[51]; return x | 64'h0008_0000_0000_0000; end
      if (!sg) return one;
      if (c[3]) begin iv = 1; return 64'hFFF8_0000_0000_0000; end
      return sone;
    end
    if (ex == 0 && fr == 0) return sg ? sone : one;
    if (sg && c[3]) begin iv = 1; return 64'hFFF8_0000_0000_0000; end
    if (ex == 0) begin
      dn = 1; ex = 1023; j = 0;
      while (!j) begin j = fr[51]; fr = fr << 1; ex = ex - 1; end
    end
    ue = ex - 1023;
    odd = (ue % 2) != 0;
    case (c[1:0])
      2'd0: ex = 1023;
      2'd1: ex = odd ? 1022 : 1023;
      2'd2: ex = 1022;
      default: ex = fr[51] ? 1022 : 1023;
    endcase
    return {(c[2] ? 1'b0 : sg), 11'(ex), fr};
  endfunction

  function automatic bit is_special(input logic [63:0] x);
    return x[63] || x[62:52] == 11'h7FF || x[62:52] == 11'h000;
  endfunction

  // behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_dst = '0; m_valid = 0; m_inv = 0; m_den = 0; m_undef = 0;
    end else begin
      m_valid = in_valid;
      if (in_valid) begin
        int n;
        bit ok;
        n = (vlen_sel == 2'b00) ? 2 : (vlen_sel == 2'b01) ? 4 : 8;
        ok = (enc_chk == 4'b1111);
        m_undef = !ok; m_inv = 0; m_den = 0;
        for (int i = 0; i < L; i++) begin
          logic [63:0] a;
          bit iv, dn;
          a = bcast ? src[63:0] : src[i*64 +: 64];
          if (!ok) begin
            m_dst[i*64 +: 64] = old_dst[i*64 +: 64]; m_tag[i] = "R9";
          end else if (i >= n) begin
            m_dst[i*64 +: 64] = '0; m_tag[i] = "R1";
          end else if (!mask_en || lane_mask[i]) begin
            m_dst[i*64 +: 64] = ref_mant(a, ctrl, iv, dn);
            m_inv = m_inv | iv; m_den = m_den | dn;
            m_tag[i] = bcast ? "R5" : is_special(a) ? "R7" : !mask_en ? "R2" : "R6";
          end else if (zero_mode) begin
            m_dst[i*64 +: 64] = '0; m_tag[i] = "R4";
          end else begin
            m_dst[i*64 +: 64] = old_dst[i*64 +: 64]; m_tag[i] = "R3";
          end
        end
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(out_valid === m_valid, "R10 out_valid", 64'(out_valid), 64'(m_valid));
      chk(flag_inv === m_inv, "R8 flag_inv", 64'(flag_inv), 64'(m_inv));
      chk(flag_den === m_den, "R8 flag_den", 64'(flag_den), 64'(m_den));
      chk(undef_op === m_undef, "R9 undef_op", 64'(undef_op), 64'(m_undef));
      for (int i = 0; i < L; i++)
        if (m_tag[i] != "")
          chk(dst[i*64 +: 64] === m_dst[i*64 +: 64], m_tag[i], dst[i*64 +: 64], m_dst[i*64 +: 64]);
    end
  end

  logic [63:0] vals [12];
  logic [7:0]  pats [5];

  task automatic drive(input int k, input logic [3:0] enc);
    @(negedge clk);
    in_valid = (k % 7 != 6);
    enc_chk = enc;
    for (int i = 0; i < L; i++) begin
      src[i*64 +: 64]     = vals[(i + k) % 12];
      old_dst[i*64 +: 64] = {32'hC0DE_0000 | 32'(i), 32'(k)};
    end
  endtask

  initial begin
    int k;
    vals[0]  = 64'h3FF0_0000_0000_0000;  // 1.0
    vals[1]  = 64'h4008_0000_0000_0000;  // 3.0
    vals[2]  = 64'hC004_0000_0000_0000;  // -2.5
    vals[3]  = 64'h3FE8_0000_0000_0000;  // 0.75
    vals[4]  = 64'h0000_0000_0000_0001;  // subnormal
    vals[5]  = 64'h0008_0000_0000_0000;  // subnormal
    vals[6]  = 64'h0000_0000_0000_0000;  // +0
    vals[7]  = 64'h8000_0000_0000_0000;  // -0
    vals[8]  = 64'h7FF0_0000_0000_0000;  // +inf
    vals[9]  = 64'hFFF0_0000_0000_0000;  // -inf
    vals[10] = 64'h7FF0_0000_0000_0001;  // signalling NaN
    vals[11] = 64'h800F_0000_0000_0000;  // negative subnormal
    pats[0] = 8'hFF; pats[1] = 8'h00; pats[2] = 8'hA5; pats[3] = 8'h3C; pats[4] = 8'h01;

    repeat (3) @(posedge clk);
    #1;
    chk(dst === '0, "R10 reset dst", dst[63:0], 64'd0);
    chk(out_valid === 1'b0, "R10 reset out_valid", 64'(out_valid), 64'd0);
    chk(undef_op === 1'b0, "R10 reset undef_op", 64'(undef_op), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    k = 0;
    for (int vl = 0; vl < 3; vl++)
      for (int mp = 0; mp < 5; mp++)
        for (int me = 0; me < 2; me++)
          for (int zm = 0; zm < 2; zm++)
            for (int bc = 0; bc < 2; bc++)
              for (int c = 0; c < 16; c++) begin
                vlen_sel = 2'(vl); lane_mask = pats[mp]; mask_en = me[0];
                zero_mode = zm[0]; bcast = bc[0]; ctrl = 4'(c);
                drive(k, 4'b1111);
                k++;
              end

    vlen_sel = 2'b11; mask_en = 1'b0; bcast = 1'b0; ctrl = 4'b1001;
    drive(1, 4'b0111);
    drive(2, 4'b1110);
    drive(3, 4'b0000);
    drive(4, 4'b1111);

    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL R10 watchdog expired: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule